// File: doc/BRIEF.md
# Dual-Mode Timer with Event Output and Capture

A 32-bit up-counting timer peripheral driven through a single-cycle memory-mapped port. Software programs a control word that starts and stops the counter, enables reload-on-wrap, divides the count rate through a power-of-two prescaler, arms a compare against a match register, shapes an output pin from timer events, and selects which edges of an external event input latch the counter into a capture register. Three event sources (match, wrap, capture) feed a write-one-to-clear status register. That register is masked by an enable register and collapsed into one interrupt line.

Writes to the timing registers are posted. They land in a staging register and take effect one clock later, and a pending register shows which write is still in flight. A software reload register copies the load value into the counter on any write. A soft-reset command holds every timer register at its reset value for a fixed number of clocks, and a status bit reports when this is complete.

Top module: `dmt_timer`

## Requirements
- R1: While control bit 0 is 1 and the prescaler is off, the counter rises by one on every clock. While bit 0 is 0, the counter holds its value.
- R2: A tick at value all-ones raises a wrap event and sets status bit 1. The counter then goes to 0, or to the load register when control bit 1 is set.
- R3: When control bit 5 is set, the counter advances once every 2^(P+1) running clocks, where P is control bits 4:2. The division count restarts whenever the counter is stopped.
- R4: When control bit 6 is set, a tick that brings the counter to the match register value sets status bit 0. When control bit 6 is clear, no match is recorded.
- R5: Control bits 11:10 select the output events: 0 or 3 = none, 1 = wrap only, 2 = wrap and match. With no events selected, the output drives the default level given by control bit 7. When control bit 12 is 1, each event inverts the output. When control bit 12 is 0, each event drives the inverse of the default level for exactly one clock.
- R6: The event input passes through a two-stage synchronizer. Control bits 9:8 pick the edges that capture: 1 = rising, 2 = falling, 3 = both, 0 = none. A selected edge copies the counter into the capture register and sets status bit 2. An edge that is not selected changes neither.
- R7: Any write to the reload register copies the load register into the counter.
- R8: Writes to control, counter, load, reload and match take effect one clock after the bus write. During that clock the pending register reads bit 0 (control), 1 (counter), 2 (load), 3 (reload) or 4 (match) as 1. At all other times it reads 0.
- R9: A write to the interface-control register with bit 1 set starts a soft reset. For RST_CYCLES clocks, system-status bit 0 reads 0 and all timer registers, status, enables and the output are held at reset values. After that, bit 0 reads 1.
- R10: Writing 1 to a status bit clears it. A status bit that sets in the same clock as the clear stays set. The interrupt output equals the OR of status ANDed with the enable register, delayed by one clock.
- R11: Byte offsets: 0x00 identity, 0x14 system status, 0x18 status, 0x1C enable, 0x24 control, 0x28 counter, 0x2C load, 0x30 reload, 0x34 pending, 0x38 match, 0x3C capture, 0x40 interface control. Read data is registered and appears one clock after the read. After reset, every register reads 0 except identity (ID_VALUE) and system status (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one clock per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| evt_in | input | 1 | Asynchronous event input for capture |
| pwm_out | output | 1 | Registered event/PWM output pin |
| irq | output | 1 | Registered interrupt request |

## Verification
The bound checker checks several properties on every cycle. The pending register never shows more than one in-flight write. A stopped counter with no write or reload pending keeps its value. A wrap with reload enabled lands on the old load value. A soft reset clears the control word. A zero enable mask keeps the interrupt low. With no events selected, the output follows the default level. Exact tick counts under each prescale setting, the single-clock width of pulse-mode output, edge selection on the capture input, and the pending and reset-done read sequences depend on particular register programming, so only the bench scenarios show them.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  localparam logic [7:0] OFF_IDENT  = 8'h00;
  localparam logic [7:0] OFF_SYSST  = 8'h14;
  localparam logic [7:0] OFF_STAT   = 8'h18;
  localparam logic [7:0] OFF_IEN    = 8'h1C;
  localparam logic [7:0] OFF_CTRL   = 8'h24;
  localparam logic [7:0] OFF_COUNT  = 8'h28;
  localparam logic [7:0] OFF_LOAD   = 8'h2C;
  localparam logic [7:0] OFF_RELOAD = 8'h30;
  localparam logic [7:0] OFF_PEND   = 8'h34;
  localparam logic [7:0] OFF_MATCH  = 8'h38;
  localparam logic [7:0] OFF_CAPT   = 8'h3C;
  localparam logic [7:0] OFF_IFCTL  = 8'h40;

  localparam int PEND_BITS = 5;
  localparam int PB_CTRL   = 0;
  localparam int PB_COUNT  = 1;
  localparam int PB_LOAD   = 2;
  localparam int PB_RELOAD = 3;
  localparam int PB_MATCH  = 4;

  localparam int CTRL_BITS = 13;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_WRAP = 2'd1,
    OUT_BOTH = 2'd2,
    OUT_RSVD = 2'd3
  } out_sel_e;

  // Field layout follows the control-word bit positions (bit 12 down to bit 0).
  typedef struct packed {
    logic       toggle;
    out_sel_e   out_sel;
    logic [1:0] cap_edge;
    logic       def_lvl;
    logic       cmp_en;
    logic       pre_en;
    logic [2:0] ptv;
    logic       auto_rl;
    logic       run;
  } ctrl_t;

endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
  parameter int PCW = 8
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       run,
  input  logic       pre_en,
  input  logic [2:0] ptv,
  output logic       tick
);
  logic [PCW-1:0] pcnt_q;
  logic [PCW-1:0] mask;

  always_comb begin
    mask = ~({PCW{1'b1}} << ({1'b0, ptv} + 4'd1));
    tick = run && (!pre_en || ((pcnt_q & mask) == mask));
  end

  always_ff @(posedge clk) begin
    if (clr || !run) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + PCW'(1);
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  input  logic         reload,
  input  logic [W-1:0] load_val,
  input  logic         auto_rl,
  input  logic         cmp_en,
  input  logic [W-1:0] match_val,
  output logic [W-1:0] cnt,
  output logic         wrap_evt,
  output logic         match_evt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] tick_nxt;
  logic         at_top;
  logic         free;

  always_comb begin
    at_top    = &cnt_q;
    free      = tick && !wr_cnt && !reload;
    tick_nxt  = at_top ? (auto_rl ? load_val : '0) : cnt_q + W'(1);
    wrap_evt  = free && at_top;
    match_evt = free && cmp_en && (tick_nxt == match_val);
  end

  always_ff @(posedge clk) begin
    if (clr)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_val;
    else if (reload) cnt_q <= load_val;
    else if (tick)   cnt_q <= tick_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dmt_capture.sv
module dmt_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         evt_in,
  input  logic [1:0]   edge_sel,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cap_val,
  output logic         cap_evt
);
  logic s1_q, s2_q, prev_q;
  logic [W-1:0] cap_q;
  logic rise, fall;

  always_comb begin
    rise    = s2_q && !prev_q;
    fall    = !s2_q && prev_q;
    cap_evt = (edge_sel[0] && rise) || (edge_sel[1] && fall);
  end

  always_ff @(posedge clk) begin
    s1_q   <= evt_in;
    s2_q   <= s1_q;
    prev_q <= s2_q;
    if (clr)          cap_q <= '0;
    else if (cap_evt) cap_q <= cnt;
  end

  assign cap_val = cap_q;
endmodule

// File: rtl/dmt_pwm.sv
module dmt_pwm
  import dmt_pkg::*;
(
  input  logic     clk,
  input  logic     clr,
  input  logic     def_lvl,
  input  logic     toggle,
  input  out_sel_e out_sel,
  input  logic     wrap_evt,
  input  logic     match_evt,
  output logic     pwm
);
  logic evt;
  logic idle;
  logic pwm_q;

  always_comb begin
    idle = (out_sel == OUT_NONE) || (out_sel == OUT_RSVD);
    evt  = ((out_sel == OUT_WRAP) && wrap_evt) ||
           ((out_sel == OUT_BOTH) && (wrap_evt || match_evt));
  end

  always_ff @(posedge clk) begin
    if (clr)         pwm_q <= 1'b0;
    else if (idle)   pwm_q <= def_lvl;
    else if (toggle) pwm_q <= evt ? !pwm_q : pwm_q;
    else             pwm_q <= evt ? !def_lvl : def_lvl;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
  import dmt_pkg::*;
#(
  parameter int          W          = 32,
  parameter int          AW         = 8,
  parameter int          PCW        = 8,
  parameter int          RST_CYCLES = 8,
  parameter logic [31:0] ID_VALUE   = 32'h0000_0D17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          evt_in,
  output logic          pwm_out,
  output logic          irq
);
  localparam int RCW = $clog2(RST_CYCLES + 1);
  localparam int NEV = 3;

  ctrl_t                ctrl_q;
  logic [W-1:0]         load_q, match_q, stage_q, rdata_q;
  logic [PEND_BITS-1:0] pend_q, pend_d;
  logic [NEV-1:0]       ien_q, stat_q, stat_set, stat_clr;
  logic                 srst_busy;
  logic [RCW-1:0]       srst_cnt;
  logic                 irq_q;
  logic                 clr, wr, rd;
  logic                 tick, wrap_evt, match_evt, cap_evt;
  logic [W-1:0]         cnt, cap_val;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] off);
    return a == AW'(off);
  endfunction

  assign wr  = bus_en && bus_we;
  assign rd  = bus_en && !bus_we;
  assign clr = rst || srst_busy;

  // Posted writes: staged one clock, then committed.
  always_comb begin
    pend_d = '0;
    if (wr) begin
      pend_d[PB_CTRL]   = hit(bus_addr, OFF_CTRL);
      pend_d[PB_COUNT]  = hit(bus_addr, OFF_COUNT);
      pend_d[PB_LOAD]   = hit(bus_addr, OFF_LOAD);
      pend_d[PB_RELOAD] = hit(bus_addr, OFF_RELOAD);
      pend_d[PB_MATCH]  = hit(bus_addr, OFF_MATCH);
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      pend_q  <= '0;
      stage_q <= '0;
    end else begin
      pend_q  <= pend_d;
      if (|pend_d) stage_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (pend_q[PB_CTRL])  ctrl_q  <= ctrl_t'(stage_q[CTRL_BITS-1:0]);
      if (pend_q[PB_LOAD])  load_q  <= stage_q;
      if (pend_q[PB_MATCH]) match_q <= stage_q;
    end
  end

  // Soft reset sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      srst_busy <= 1'b0;
      srst_cnt  <= '0;
    end else if (wr && hit(bus_addr, OFF_IFCTL) && bus_wdata[1]) begin
      srst_busy <= 1'b1;
      srst_cnt  <= RCW'(RST_CYCLES - 1);
    end else if (srst_busy) begin
      if (srst_cnt == '0) srst_busy <= 1'b0;
      else                srst_cnt  <= srst_cnt - RCW'(1);
    end
  end

  // Interrupt status and enable.
  assign stat_set = {cap_evt, wrap_evt, match_evt};
  assign stat_clr = (wr && hit(bus_addr, OFF_STAT)) ? bus_wdata[NEV-1:0] : '0;

  always_ff @(posedge clk) begin
    if (clr) begin
      stat_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (wr && hit(bus_addr, OFF_IEN)) ien_q <= bus_wdata[NEV-1:0];
      irq_q  <= |(stat_q & ien_q);
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= '0;
      case (bus_addr)
        AW'(OFF_IDENT):  rdata_q <= W'(ID_VALUE);
        AW'(OFF_SYSST):  rdata_q <= W'(!srst_busy);
        AW'(OFF_STAT):   rdata_q <= W'(stat_q);
        AW'(OFF_IEN):    rdata_q <= W'(ien_q);
        AW'(OFF_CTRL):   rdata_q <= W'(ctrl_q);
        AW'(OFF_COUNT):  rdata_q <= cnt;
        AW'(OFF_LOAD):   rdata_q <= load_q;
        AW'(OFF_PEND):   rdata_q <= W'(pend_q);
        AW'(OFF_MATCH):  rdata_q <= match_q;
        AW'(OFF_CAPT):   rdata_q <= cap_val;
        default:         rdata_q <= '0;
      endcase
    end
  end

  dmt_prescaler #(.PCW(PCW)) u_pre (
    .clk(clk), .clr(clr), .run(ctrl_q.run), .pre_en(ctrl_q.pre_en),
    .ptv(ctrl_q.ptv), .tick(tick)
  );

  dmt_counter #(.W(W)) u_cnt (
    .clk(clk), .clr(clr), .tick(tick),
    .wr_cnt(pend_q[PB_COUNT]), .wr_val(stage_q),
    .reload(pend_q[PB_RELOAD]), .load_val(load_q),
    .auto_rl(ctrl_q.auto_rl), .cmp_en(ctrl_q.cmp_en), .match_val(match_q),
    .cnt(cnt), .wrap_evt(wrap_evt), .match_evt(match_evt)
  );

  dmt_capture #(.W(W)) u_cap (
    .clk(clk), .clr(clr), .evt_in(evt_in), .edge_sel(ctrl_q.cap_edge),
    .cnt(cnt), .cap_val(cap_val), .cap_evt(cap_evt)
  );

  dmt_pwm u_pwm (
    .clk(clk), .clr(clr), .def_lvl(ctrl_q.def_lvl), .toggle(ctrl_q.toggle),
    .out_sel(ctrl_q.out_sel), .wrap_evt(wrap_evt), .match_evt(match_evt),
    .pwm(pwm_out)
  );

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dmt_timer_chk.sv
module dmt_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [12:0]  ctrl,
  input logic [4:0]   pend,
  input logic         busy,
  input logic [W-1:0] cnt,
  input logic [W-1:0] load,
  input logic         wrap_evt,
  input logic [2:0]   ien,
  input logic         irq,
  input logic         pwm_out
);
  p_pend_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend));

  p_hold_stopped_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] && !pend[1] && !pend[3] && !busy) |=> $stable(cnt));

  p_wrap_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && ctrl[1] && !busy) |=> (cnt == $past(load)));

  p_srst_clears_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (ctrl == 13'd0));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
    (ien == 3'd0) |=> !irq);

  p_out_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl[11:10] == 2'b00 && !busy) |=> (pwm_out == $past(ctrl[7])));
endmodule

bind dmt_timer dmt_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .ctrl(ctrl_q), .pend(pend_q), .busy(srst_busy),
  .cnt(cnt), .load(load_q), .wrap_evt(wrap_evt), .ien(ien_q),
  .irq(irq), .pwm_out(pwm_out)
);

// File: tb/dmt_timer_tb_top.sv
module dmt_timer_tb_top;
  import dmt_pkg::*;

  localparam logic [31:0] IDV = 32'h0000_0D17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_in = 1'b0;
  logic        pwm_out, irq;

  always #5 clk = ~clk;

  dmt_timer #(.ID_VALUE(IDV)) dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .pwm_out(pwm_out), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  logic [31:0] mask_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        low_en = 1'b0;
  int          low_cnt = 0;
  bit          done = 0;

  always @(posedge clk) rd_seen <= bus_en && !bus_we;

  // Monitor: pops expected read results as the design returns them.
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read data %h", bus_rdata);
      end else begin
        logic [31:0] e, m;
        string t;
        e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
        if ((bus_rdata & m) != (e & m)) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h (mask %h)", t, bus_rdata, e, m);
        end
      end
    end
    if (low_en && !pwm_out) low_cnt++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e,
                        input logic [31:0] m, input string t);
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Start with ctrl_on, wait 10, write ctrl_off: 11 running clocks.
  task automatic run_window(input logic [31:0] on, input logic [31:0] off);
    wr(OFF_CTRL, on);
    idle(10);
    wr(OFF_CTRL, off);
    idle(3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    rd_exp(OFF_IDENT, IDV, '1, "R11 identity");
    rd_exp(OFF_SYSST, 32'd1, '1, "R11 sysstatus after reset");
    rd_exp(OFF_CTRL, 32'd0, '1, "R11 control reset");
    rd_exp(OFF_COUNT, 32'd0, '1, "R11 counter reset");
    chk(pwm_out, 1'b0, "R11 output reset");
    chk(irq, 1'b0, "R11 irq reset");

    // R8 posted writes
    wr(OFF_LOAD, 32'h10);
    rd_exp(OFF_PEND, 32'h04, '1, "R8 pending load");
    rd_exp(OFF_PEND, 32'h00, '1, "R8 pending cleared");
    rd_exp(OFF_LOAD, 32'h10, '1, "R8 load committed");
    wr(OFF_MATCH, 32'h3);
    rd_exp(OFF_PEND, 32'h10, '1, "R8 pending match");

    // R1 run and hold
    wr(OFF_COUNT, 32'd5);
    idle(4);
    rd_exp(OFF_COUNT, 32'd5, '1, "R1 stopped holds");
    wr(OFF_COUNT, 32'd0);
    run_window(32'h1, 32'h0);
    rd_exp(OFF_COUNT, 32'd11, '1, "R1 one per clock");
    idle(5);
    rd_exp(OFF_COUNT, 32'd11, '1, "R1 hold after stop");

    // R3 prescaler
    wr(OFF_COUNT, 32'd0);
    run_window(32'h25, 32'h0);
    rd_exp(OFF_COUNT, 32'd2, '1, "R3 divide by 4");
    wr(OFF_COUNT, 32'd0);
    run_window(32'h21, 32'h0);
    rd_exp(OFF_COUNT, 32'd5, '1, "R3 divide by 2");

    // R2 wrap with and without reload
    wr(OFF_STAT, 32'h7);
    wr(OFF_COUNT, 32'hFFFF_FFFE);
    wr(OFF_LOAD, 32'h100);
    wr(OFF_IEN, 32'h2);
    run_window(32'h3, 32'h2);
    rd_exp(OFF_COUNT, 32'h109, '1, "R2 wrap to load");
    rd_exp(OFF_STAT, 32'h2, 32'h2, "R2 wrap status");
    chk(irq, 1'b1, "R10 irq on enabled wrap");
    wr(OFF_STAT, 32'h2);
    idle(2);
    rd_exp(OFF_STAT, 32'h0, 32'h7, "R10 write-one clear");
    chk(irq, 1'b0, "R10 irq drops after clear");
    wr(OFF_COUNT, 32'hFFFF_FFFE);
    run_window(32'h1, 32'h0);
    rd_exp(OFF_COUNT, 32'd9, '1, "R2 wrap to zero");
    wr(OFF_STAT, 32'h7);

    // R4 compare
    wr(OFF_IEN, 32'h1);
    wr(OFF_MATCH, 32'd5);
    wr(OFF_COUNT, 32'd0);
    run_window(32'h41, 32'h40);
    rd_exp(OFF_STAT, 32'h1, 32'h1, "R4 match status");
    chk(irq, 1'b1, "R10 irq on enabled match");
    wr(OFF_STAT, 32'h7);
    wr(OFF_COUNT, 32'd0);
    run_window(32'h01, 32'h00);
    rd_exp(OFF_STAT, 32'h0, 32'h1, "R4 no match when disabled");
    wr(OFF_IEN, 32'h0);
    wr(OFF_STAT, 32'h7);

    // R7 reload register
    wr(OFF_LOAD, 32'h77);
    wr(OFF_RELOAD, 32'h0);
    idle(2);
    rd_exp(OFF_COUNT, 32'h77, '1, "R7 reload copies load");

    // R5 output
    wr(OFF_CTRL, 32'h1400);
    idle(2);
    chk(pwm_out, 1'b0, "R5 toggle start level");
    wr(OFF_COUNT, 32'hFFFF_FFFE);
    run_window(32'h1401, 32'h1400);
    chk(pwm_out, 1'b1, "R5 toggle on wrap");
    wr(OFF_CTRL, 32'h0080);
    idle(2);
    chk(pwm_out, 1'b1, "R5 idle default high");
    wr(OFF_CTRL, 32'h0000);
    idle(2);
    chk(pwm_out, 1'b0, "R5 idle default low");
    wr(OFF_CTRL, 32'h0080);
    wr(OFF_COUNT, 32'hFFFF_FFFE);
    wr(OFF_MATCH, 32'd3);
    idle(2);
    low_cnt = 0; low_en = 1'b1;
    run_window(32'h08C1, 32'h0880);
    low_en = 1'b0;
    checks++;
    if (low_cnt != 2) begin
      errors++;
      $display("FAIL R5 pulse count: actual=%0d expected=2", low_cnt);
    end
    chk(pwm_out, 1'b1, "R5 pulse returns to default");
    wr(OFF_CTRL, 32'h0);
    wr(OFF_STAT, 32'h7);

    // R6 capture
    wr(OFF_COUNT, 32'h42);
    wr(OFF_CTRL, 32'h100);
    idle(2);
    evt_in = 1'b1;
    idle(5);
    rd_exp(OFF_CAPT, 32'h42, '1, "R6 rising capture");
    rd_exp(OFF_STAT, 32'h4, 32'h4, "R6 capture status");
    wr(OFF_STAT, 32'h4);
    wr(OFF_COUNT, 32'h55);
    idle(2);
    evt_in = 1'b0;
    idle(5);
    rd_exp(OFF_CAPT, 32'h42, '1, "R6 falling edge ignored");
    rd_exp(OFF_STAT, 32'h0, 32'h4, "R6 no status on ignored edge");
    wr(OFF_CTRL, 32'h300);
    idle(2);
    evt_in = 1'b1;
    idle(5);
    rd_exp(OFF_CAPT, 32'h55, '1, "R6 both-edge capture");

    // R9 soft reset
    wr(OFF_IEN, 32'h7);
    wr(OFF_LOAD, 32'h99);
    wr(OFF_CTRL, 32'h80);
    idle(2);
    wr(OFF_IFCTL, 32'h06);
    rd_exp(OFF_SYSST, 32'h0, 32'h1, "R9 reset in progress");
    idle(12);
    rd_exp(OFF_SYSST, 32'h1, 32'h1, "R9 reset done");
    rd_exp(OFF_CTRL, 32'h0, '1, "R9 control cleared");
    rd_exp(OFF_LOAD, 32'h0, '1, "R9 load cleared");
    rd_exp(OFF_IEN, 32'h0, '1, "R9 enable cleared");
    rd_exp(OFF_COUNT, 32'h0, '1, "R9 counter cleared");
    chk(pwm_out, 1'b0, "R9 output cleared");

    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads never returned", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule